// File: doc/BRIEF.md
# Collision Backoff and Retry Controller

This block is the part of a half-duplex transmitter that reacts to a collision. It watches a collision input while a frame is on the wire and, when one arrives, asks the serializer to send a 32-bit jam. If the serializer is still in the preamble or start-of-frame delimiter, the jam request is held until those fields are done. After the jam it draws a random slot count and counts that many slot times using a bit-time clock enable. Then it either pulses a retry request or, if this was the sixteenth collision in a row, pulses an abandon error.

The random slot count is a 10-bit pseudo-random value XORed with the low ten bits of the transmit data present in the draw cycle. It is then masked to the low n bits, where n is the number of collisions so far, capped at ten. A late collision is handled exactly like an early one: any collision seen while the transmitter is active starts the same sequence. The attempt count is cleared when the frame completes or when it is abandoned.

States: IDLE (waiting for a collision), HOLD_PRE (collision seen inside preamble or delimiter), JAM (jam requested), DRAW (random value latched), WAIT (slot countdown), RETRY (one-cycle retry pulse), ABORT (one-cycle abandon pulse). The transitions are: IDLE to HOLD_PRE or JAM on an accepted collision; HOLD_PRE to JAM when the preamble flag drops; JAM to DRAW, or to ABORT on the final permitted attempt, after the last jam bit; DRAW to WAIT; WAIT to RETRY when the countdown is empty; RETRY and ABORT back to IDLE.

Top module: `backoff_ctrl`

## Requirements
- R1: A collision is accepted only in IDLE while `tx_active` is high, at any point of the frame, late ones included. A collision in any other state, or with `tx_active` low, has no effect on the outputs.
- R2: When `in_preamble` is high in the cycle a collision is accepted, `jam_req` stays low until the first clock edge at which `in_preamble` is seen low. It rises in the cycle after that edge.
- R3: `jam_req` stays high for exactly 32 `bit_en` pulses and falls right after the edge that samples the 32nd.
- R4: The generator shifts left every clock, with new bit 0 equal to bit 9 XOR bit 6 (x^10 + x^7 + 1), and resets to 10'h2A5. The raw draw is the generator value XOR `tx_data_lo`, both taken in the DRAW cycle, which is the cycle right after `jam_req` falls.
- R5: After the n-th consecutive collision, only bits [min(n,10)-1:0] of the raw draw form the slot count.
- R6: `backoff_busy` is high for one DRAW cycle, then for as long as it takes `bit_en` to pulse slot count × SLOT_BITS times (default 512). With a slot count of zero it stays high for one extra cycle only.
- R7: `retry_req` is a single-cycle pulse in the cycle after `backoff_busy` falls.
- R8: The 16th consecutive collision is followed by its jam and then a single-cycle `abort_err` pulse, with no backoff and no retry. The attempt count then restarts at zero.
- R9: `tx_done` in IDLE clears the attempt count, so the next collision uses a 1-bit mask. When `tx_done` and an accepted collision fall in the same cycle, the collision wins and the count is not cleared.
- R10: During and right after reset, `jam_req`, `backoff_busy`, `retry_req` and `abort_err` are low and the attempt count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One pulse per transmitted bit time |
| tx_active | input | 1 | A frame is being transmitted |
| in_preamble | input | 1 | Serializer is in preamble or start delimiter |
| collision | input | 1 | Collision detected on the medium |
| tx_done | input | 1 | Frame finished without collision |
| tx_data_lo | input | 10 | Low ten bits of the current transmit data |
| jam_req | output | 1 | Request the serializer to send jam bits |
| backoff_busy | output | 1 | Draw or slot countdown in progress |
| retry_req | output | 1 | One-cycle pulse: restart the frame |
| abort_err | output | 1 | One-cycle pulse: attempts exhausted, frame dropped |

## Verification
Two events can fall in the same cycle: a frame completing and a new collision being accepted. The bench drives `tx_done` and `collision` together in IDLE after several collisions have built up the count. It then judges which one took priority from the length of the next backoff, using a forced all-ones draw so that the mask width shows directly in the slot count. The transmit data in the draw cycle is also set from the bench's own copy of the generator. This steers the slot count, so that the sixteenth-attempt abandon and the ten-bit mask cap can be reached within the run length.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD_PRE,
        ST_JAM,
        ST_DRAW,
        ST_WAIT,
        ST_RETRY,
        ST_ABORT
    } bo_state_e;

endpackage

// File: rtl/bo_lfsr.sv
module bo_lfsr #(
    parameter int          WIDTH = 10,
    parameter int          TAP_A = 9,
    parameter int          TAP_B = 6,
    parameter logic [WIDTH-1:0] SEED = 10'h2A5
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] value
);

    logic [WIDTH-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= SEED;
        end else begin
            sr_q <= {sr_q[WIDTH-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
        end
    end

    assign value = sr_q;

endmodule

// File: rtl/bo_slot_timer.sv
module bo_slot_timer #(
    parameter int CNT_W     = 10,
    parameter int SLOT_BITS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_slots,
    input  logic             run,
    input  logic             bit_en,
    output logic             empty
);

    localparam int BIT_W = (SLOT_BITS > 1) ? $clog2(SLOT_BITS) : 1;

    logic [CNT_W-1:0] slots_q;
    logic [BIT_W-1:0] bits_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
            bits_q  <= '0;
        end else if (load) begin
            slots_q <= load_slots;
            bits_q  <= '0;
        end else if (run && bit_en && (slots_q != '0)) begin
            if (bits_q == BIT_W'(SLOT_BITS - 1)) begin
                bits_q  <= '0;
                slots_q <= slots_q - 1'b1;
            end else begin
                bits_q <= bits_q + 1'b1;
            end
        end
    end

    assign empty = (slots_q == '0);

endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
    import backoff_pkg::*;
#(
    parameter int               RAND_W    = 10,
    parameter int               MAX_TRIES = 16,
    parameter int               JAM_BITS  = 32,
    parameter int               SLOT_BITS = 512,
    parameter logic [RAND_W-1:0] LFSR_SEED = 10'h2A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              tx_active,
    input  logic              in_preamble,
    input  logic              collision,
    input  logic              tx_done,
    input  logic [RAND_W-1:0] tx_data_lo,
    output logic              jam_req,
    output logic              backoff_busy,
    output logic              retry_req,
    output logic              abort_err
);

    localparam int ATT_W = $clog2(MAX_TRIES + 1);
    localparam int JAM_W = $clog2(JAM_BITS);

    bo_state_e         state_q, state_d;
    logic [ATT_W-1:0]  att_q;
    logic [JAM_W-1:0]  jam_q;
    logic              coll_take;
    logic              jam_last;
    logic [RAND_W-1:0] lfsr_val;
    logic [RAND_W-1:0] draw_mask;
    logic [RAND_W-1:0] draw_val;
    logic              timer_empty;

    assign coll_take = (state_q == ST_IDLE) && collision && tx_active;
    assign jam_last  = (state_q == ST_JAM) && bit_en &&
                       (jam_q == JAM_W'(JAM_BITS - 1));

    bo_lfsr #(
        .WIDTH (RAND_W),
        .TAP_A (RAND_W - 1),
        .TAP_B (6),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (lfsr_val)
    );

    // bit i joins the draw once more than i collisions have been seen
    for (genvar i = 0; i < RAND_W; i++) begin : g_mask
        assign draw_mask[i] = (att_q > ATT_W'(i));
    end

    assign draw_val = (lfsr_val ^ tx_data_lo) & draw_mask;

    bo_slot_timer #(
        .CNT_W     (RAND_W),
        .SLOT_BITS (SLOT_BITS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (state_q == ST_DRAW),
        .load_slots (draw_val),
        .run        (state_q == ST_WAIT),
        .bit_en     (bit_en),
        .empty      (timer_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (coll_take) begin
                    state_d = in_preamble ? ST_HOLD_PRE : ST_JAM;
                end
            end
            ST_HOLD_PRE: begin
                if (!in_preamble) begin
                    state_d = ST_JAM;
                end
            end
            ST_JAM: begin
                if (jam_last) begin
                    state_d = (att_q == ATT_W'(MAX_TRIES)) ? ST_ABORT : ST_DRAW;
                end
            end
            ST_DRAW:  state_d = ST_WAIT;
            ST_WAIT: begin
                if (timer_empty) begin
                    state_d = ST_RETRY;
                end
            end
            ST_RETRY: state_d = ST_IDLE;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q <= '0;
        end else if (coll_take) begin
            att_q <= att_q + 1'b1;
        end else if ((state_q == ST_ABORT) || ((state_q == ST_IDLE) && tx_done)) begin
            att_q <= '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jam_q <= '0;
        end else if (state_q != ST_JAM) begin
            jam_q <= '0;
        end else if (bit_en) begin
            jam_q <= jam_q + 1'b1;
        end
    end

    always_comb begin
        jam_req      = 1'b0;
        backoff_busy = 1'b0;
        retry_req    = 1'b0;
        abort_err    = 1'b0;
        unique case (state_q)
            ST_JAM:   jam_req      = 1'b1;
            ST_DRAW:  backoff_busy = 1'b1;
            ST_WAIT:  backoff_busy = 1'b1;
            ST_RETRY: retry_req    = 1'b1;
            ST_ABORT: abort_err    = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/bo_ctrl_chk.sv
module bo_ctrl_chk #(
    parameter int MAX_TRIES = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           in_preamble,
    input logic                           jam_req,
    input logic                           backoff_busy,
    input logic                           retry_req,
    input logic                           abort_err,
    input logic [$clog2(MAX_TRIES+1)-1:0] att
);

    // R6
    outputs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({jam_req, backoff_busy, retry_req, abort_err}));

    // R7
    retry_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |=> !retry_req);

    // R7
    retry_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry_req |-> $past(backoff_busy));

    // R2
    jam_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(jam_req) |-> !$past(in_preamble));

    // R8
    abort_after_jam_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |-> $past(jam_req) && (att == ($clog2(MAX_TRIES+1))'(MAX_TRIES)));

    // R8
    abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_err |=> (att == '0));

    // R8
    att_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        att <= ($clog2(MAX_TRIES+1))'(MAX_TRIES));

endmodule

bind backoff_ctrl bo_ctrl_chk #(.MAX_TRIES(MAX_TRIES)) u_bo_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_preamble  (in_preamble),
    .jam_req      (jam_req),
    .backoff_busy (backoff_busy),
    .retry_req    (retry_req),
    .abort_err    (abort_err),
    .att          (att_q)
);

// File: tb/tb_backoff_ctrl.sv
module tb_backoff_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 16;
    localparam int JAMB       = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_active = 1'b0;
    logic       in_preamble = 1'b0;
    logic       collision = 1'b0;
    logic       tx_done = 1'b0;
    logic [9:0] tx_data_lo = '0;
    logic       jam_req, backoff_busy, retry_req, abort_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    // reference model state
    int         mph = 0;      // 0 idle,1 hold,2 jam,3 draw,4 wait,5 retry,6 abort
    int         mjam = 0;
    int         mleft = 0;    // bit times left
    int         matt = 0;
    logic [9:0] mlfsr = 10'h2A5;

    bit         rand_en = 0;
    bit         force_draw = 0;
    logic [9:0] target = '0;
    string      tag = "R10";

    backoff_ctrl #(.SLOT_BITS(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_active(tx_active),
        .in_preamble(in_preamble), .collision(collision), .tx_done(tx_done),
        .tx_data_lo(tx_data_lo), .jam_req(jam_req), .backoff_busy(backoff_busy),
        .retry_req(retry_req), .abort_err(abort_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference, updated at each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            mph = 0; mjam = 0; mleft = 0; matt = 0; mlfsr = 10'h2A5;
        end else begin
            logic [9:0] old_lfsr;
            old_lfsr = mlfsr;
            mlfsr = {mlfsr[8:0], mlfsr[9] ^ mlfsr[6]};
            case (mph)
                0: begin
                    if (collision && tx_active) begin
                        matt = matt + 1;
                        mjam = 0;
                        mph = in_preamble ? 1 : 2;
                    end else if (tx_done) begin
                        matt = 0;
                    end
                end
                1: if (!in_preamble) begin mph = 2; mjam = 0; end
                2: if (bit_en) begin
                    mjam = mjam + 1;
                    if (mjam == JAMB) mph = (matt == 16) ? 6 : 3;
                end
                3: begin
                    int n;
                    n = (matt > 10) ? 10 : matt;
                    mleft = int'((old_lfsr ^ tx_data_lo) & 10'((1 << n) - 1)) * SLOT;
                    mph = 4;
                end
                4: begin
                    if (mleft == 0) mph = 5;
                    else if (bit_en) mleft = mleft - 1;
                end
                5: mph = 0;
                6: begin mph = 0; matt = 0; end
                default: mph = 0;
            endcase
        end
    end

    task automatic cmp(input logic got, input logic exp, input string r);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s/%s at cycle %0d: actual %0b expected %0b", tag, r, cyc, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (!rst_n) begin
                cmp(jam_req | backoff_busy | retry_req | abort_err, 1'b0, "R10");
            end else begin
                cmp(jam_req,      mph == 2,             "R3");
                cmp(backoff_busy, mph == 3 || mph == 4, "R6");
                cmp(retry_req,    mph == 5,             "R7");
                cmp(abort_err,    mph == 6,             "R8");
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        bit_en = rand_en ? 1'($urandom % 2) : 1'b1;
        tx_data_lo = force_draw ? (mlfsr ^ target) : 10'($urandom);
    endtask

    task automatic wait_idle();
        do step(); while (mph != 0);
    endtask

    task automatic collide(input bit pre);
        step();
        tx_active = 1'b1; in_preamble = pre; collision = 1'b1;
        step();
        collision = 1'b0;
        if (pre) begin
            repeat (4) step();
            in_preamble = 1'b0;
        end
        wait_idle();
    endtask

    initial begin
        repeat (3) step();
        tag = "R10";
        rst_n = 1'b1;
        repeat (2) step();

        // R1: collision while idle transmitter is ignored
        tag = "R1";
        collision = 1'b1; tx_active = 1'b0;
        step(); step();
        collision = 1'b0;
        repeat (3) step();

        // R2: collision inside preamble, jam deferred
        tag = "R2";
        collide(1'b1);

        // R4: raw draw with free data, growing mask (R5)
        tag = "R4";
        collide(1'b0);
        tag = "R5";
        force_draw = 1; target = 10'h3FF;
        collide(1'b0);
        collide(1'b0);

        // R1: extra collision during jam ignored (late collision path)
        tag = "R1";
        step(); collision = 1'b1; tx_active = 1'b1;
        step(); collision = 1'b0;
        repeat (10) step();
        collision = 1'b1;
        step(); collision = 1'b0;
        wait_idle();

        // R9: tx_done clears count; next backoff uses one mask bit
        tag = "R9";
        step(); tx_done = 1'b1;
        step(); tx_done = 1'b0;
        collide(1'b0);
        collide(1'b0);
        // R9: simultaneous tx_done and collision, collision wins
        step(); tx_done = 1'b1; collision = 1'b1; tx_active = 1'b1;
        step(); tx_done = 1'b0; collision = 1'b0;
        wait_idle();

        // R6: sparse bit enables, zero-slot draw
        tag = "R6";
        rand_en = 1; target = 10'h000;
        collide(1'b0);
        target = 10'h155;
        collide(1'b0);
        rand_en = 0;

        // R5: cap at ten bits, then R8 abort on the sixteenth attempt
        tag = "R5";
        target = 10'h3FF;
        while (matt < 11) collide(1'b0);
        tag = "R8";
        target = 10'h003;
        while (matt != 0) collide(1'b0);
        tag = "R8";
        force_draw = 0;
        collide(1'b0);
        repeat (5) step();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule